// File: doc/BRIEF.md
# Per-CPU Priority Interrupt Selector

This block decides, for every processor attached to an interrupt controller, which interrupt ID is the most urgent one to present and whether that interrupt should actually be signalled. It receives, for each CPU, per-ID enable, pending and target bits. It also receives a shared 8-bit priority and a group bit for every ID, the two distributor group enables, and per-CPU interface controls. From these it computes a best pending ID and a pair of request lines for each CPU. A lower priority number means more urgent. ID 1023 means that nothing is pending.

Selection is split into two gates. The CPU priority mask decides whether the winning ID becomes visible as the reported pending ID. The running priority, together with the group enables, decides whether that visible ID raises a request. The winner's group chooses between the fast (FIQ) request line and the normal (IRQ) request line.

All outputs are registered. They follow any change on the inputs with a fixed latency of one clock. The whole ID space is evaluated every cycle by a comparator tree for each CPU. IDs below `N_PRIV` are private to each CPU. The remaining IDs are shared and are routed by target bits.

Top module: `intsel_top`

## Requirements
- R1: While `rst_n` is low, every `best_id_o` field reads 1023 and all `irq_o` and `fiq_o` bits are 0, whatever the other inputs are.
- R2: An ID k is a candidate for CPU c when bit c*N_ID+k of both `ena_i` and `pend_i` is set. For IDs below `N_PRIV` the target bit is not consulted. Shared IDs (k >= `N_PRIV`) also need bit c*N_ID+k of `tgt_i` set.
- R3: Among the candidates, the one with the numerically lowest priority (`prio_i[8k+7:8k]`) wins. If several candidates share that priority, the lowest ID wins.
- R4: With no candidate for a CPU, that CPU reports 1023 and raises neither request.
- R5: The winning ID is reported in `best_id_o` only if its priority is strictly below that CPU's `pmask_i` byte. Otherwise the CPU reports 1023 and raises nothing.
- R6: A reported ID raises a request only under two conditions. Its priority must be strictly below that CPU's 9-bit `run_prio_i` field, where 0x100 means nothing is running. Its group must also be enabled in both the distributor and that CPU. The group is `grp_i[k]`. The distributor enables are `dist_grp_en_i[0]` for group 0 and `dist_grp_en_i[1]` for group 1. The CPU enables are `cpu_g0_en_i` and `cpu_g1_en_i`.
- R7: A raised group-0 winner drives `fiq_o` when that CPU's `cpu_fiq_en_i` bit is 1, and drives `irq_o` otherwise. A group-1 winner always drives `irq_o`. The two lines are never high together.
- R8: A CPU is forced to report 1023 with both requests low in three cases: `dist_grp_en_i` is 0, the CPU's `cpu_if_en_i` bit is 0, or both of its group enables are 0. The other CPUs are evaluated normally.
- R9: Outputs reflect the inputs sampled at the previous rising clock edge. A change of inputs is visible after exactly one edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ena_i | input | N_CPU*N_ID | Per-CPU enable bit per ID, index c*N_ID+k |
| pend_i | input | N_CPU*N_ID | Per-CPU pending bit per ID, index c*N_ID+k |
| tgt_i | input | N_CPU*N_ID | Per-CPU target bit per ID, used for shared IDs only |
| grp_i | input | N_ID | Group of each ID (0 or 1) |
| prio_i | input | N_ID*8 | 8-bit priority of each ID, ID k at bits 8k+7:8k |
| dist_grp_en_i | input | 2 | Distributor enables, bit 0 group 0, bit 1 group 1 |
| cpu_if_en_i | input | N_CPU | CPU interface enable |
| cpu_g0_en_i | input | N_CPU | CPU group-0 enable |
| cpu_g1_en_i | input | N_CPU | CPU group-1 enable |
| cpu_fiq_en_i | input | N_CPU | Route group-0 requests to the fast line |
| pmask_i | input | N_CPU*8 | Priority mask per CPU |
| run_prio_i | input | N_CPU*9 | Running priority per CPU, 0x100 when idle |
| best_id_o | output | N_CPU*10 | Reported pending ID per CPU, 1023 when none |
| irq_o | output | N_CPU | Normal interrupt request per CPU |
| fiq_o | output | N_CPU | Fast interrupt request per CPU |

## Verification
The properties assume that every input is stable across each rising edge. They also assume that `best_id_o` values other than 1023 lie below `N_ID`. The checker keeps a one-cycle copy of the inputs and, under that assumption, relates each reported ID to the inputs that produced it. The bench changes every input only on the falling edge and keeps all IDs inside the configured range. The random patterns favour a few coarse priority levels so that ties and mask and running-priority boundaries occur often.

// File: rtl/intsel_pkg.sv
package intsel_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] IDLE_ID = 10'd1023;
  localparam logic [8:0] NONE_PRIO = 9'h100;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic            irq;
    logic            fiq;
  } cpu_res_t;

  localparam cpu_res_t RES_IDLE = '{id: IDLE_ID, irq: 1'b0, fiq: 1'b0};

  // true when the given group is enabled in both control levels
  function automatic logic group_open(input logic grp, input logic [1:0] dist_en,
                                      input logic g0_en, input logic g1_en);
    return grp ? (dist_en[1] & g1_en) : (dist_en[0] & g0_en);
  endfunction
endpackage

// File: rtl/intsel_tree.sv
module intsel_tree
  import intsel_pkg::*;
#(
  parameter int N_ID   = 64,
  parameter int N_PRIV = 32
) (
  input  logic [N_ID-1:0]   ena,
  input  logic [N_ID-1:0]   pend,
  input  logic [N_ID-1:0]   tgt,
  input  logic [N_ID-1:0]   grp,
  input  logic [N_ID*8-1:0] prio,
  output logic [8:0]        win_prio,
  output logic [ID_W-1:0]   win_id,
  output logic              win_grp
);
  localparam int LEAVES = 1 << $clog2(N_ID);
  localparam int NODES  = 2 * LEAVES - 1;

  logic [8:0]      np [NODES];
  logic [ID_W-1:0] ni [NODES];
  logic            ng [NODES];

  // leaves: one per ID, padded to a power of two with empty slots
  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N_ID) begin : g_real
      localparam logic SHARED_FREE = (j < N_PRIV);
      logic elig;
      assign elig = ena[j] & pend[j] & (tgt[j] | SHARED_FREE);
      assign np[LEAVES-1+j] = elig ? {1'b0, prio[j*8 +: 8]} : NONE_PRIO;
      assign ni[LEAVES-1+j] = ID_W'(j);
      assign ng[LEAVES-1+j] = grp[j];
    end else begin : g_pad
      assign np[LEAVES-1+j] = NONE_PRIO;
      assign ni[LEAVES-1+j] = IDLE_ID;
      assign ng[LEAVES-1+j] = 1'b0;
    end
  end

  // inner nodes: left child holds lower IDs, right wins only if strictly lower
  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    logic take_right;
    assign take_right = np[2*i+2] < np[2*i+1];
    assign np[i] = take_right ? np[2*i+2] : np[2*i+1];
    assign ni[i] = take_right ? ni[2*i+2] : ni[2*i+1];
    assign ng[i] = take_right ? ng[2*i+2] : ng[2*i+1];
  end

  assign win_prio = np[0];
  assign win_id   = ni[0];
  assign win_grp  = ng[0];
endmodule

// File: rtl/intsel_gate.sv
module intsel_gate
  import intsel_pkg::*;
(
  input  logic [8:0]      win_prio,
  input  logic [ID_W-1:0] win_id,
  input  logic            win_grp,
  input  logic [1:0]      dist_en,
  input  logic            if_en,
  input  logic            g0_en,
  input  logic            g1_en,
  input  logic            fiq_en,
  input  logic [7:0]      pmask,
  input  logic [8:0]      run_prio,
  output cpu_res_t        res
);
  logic cpu_live;
  logic visible;
  logic preempt;
  logic grp_ok;

  assign cpu_live = (|dist_en) & if_en & (g0_en | g1_en);
  assign visible  = win_prio < {1'b0, pmask};
  assign preempt  = win_prio < run_prio;
  assign grp_ok   = group_open(win_grp, dist_en, g0_en, g1_en);

  always_comb begin
    res = RES_IDLE;
    if (cpu_live && visible) begin
      res.id = win_id;
      if (preempt && grp_ok) begin
        if (!win_grp && fiq_en) res.fiq = 1'b1;
        else                    res.irq = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intsel_top.sv
module intsel_top
  import intsel_pkg::*;
#(
  parameter int N_CPU  = 2,
  parameter int N_ID   = 64,
  parameter int N_PRIV = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CPU*N_ID-1:0] ena_i,
  input  logic [N_CPU*N_ID-1:0] pend_i,
  input  logic [N_CPU*N_ID-1:0] tgt_i,
  input  logic [N_ID-1:0]       grp_i,
  input  logic [N_ID*8-1:0]     prio_i,
  input  logic [1:0]            dist_grp_en_i,
  input  logic [N_CPU-1:0]      cpu_if_en_i,
  input  logic [N_CPU-1:0]      cpu_g0_en_i,
  input  logic [N_CPU-1:0]      cpu_g1_en_i,
  input  logic [N_CPU-1:0]      cpu_fiq_en_i,
  input  logic [N_CPU*8-1:0]    pmask_i,
  input  logic [N_CPU*9-1:0]    run_prio_i,
  output logic [N_CPU*10-1:0]   best_id_o,
  output logic [N_CPU-1:0]      irq_o,
  output logic [N_CPU-1:0]      fiq_o
);
  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    logic [8:0]      win_prio;
    logic [ID_W-1:0] win_id;
    logic            win_grp;
    cpu_res_t        nxt;
    cpu_res_t        cur_q;

    intsel_tree #(.N_ID(N_ID), .N_PRIV(N_PRIV)) u_tree (
      .ena      (ena_i[c*N_ID +: N_ID]),
      .pend     (pend_i[c*N_ID +: N_ID]),
      .tgt      (tgt_i[c*N_ID +: N_ID]),
      .grp      (grp_i),
      .prio     (prio_i),
      .win_prio (win_prio),
      .win_id   (win_id),
      .win_grp  (win_grp)
    );

    intsel_gate u_gate (
      .win_prio (win_prio),
      .win_id   (win_id),
      .win_grp  (win_grp),
      .dist_en  (dist_grp_en_i),
      .if_en    (cpu_if_en_i[c]),
      .g0_en    (cpu_g0_en_i[c]),
      .g1_en    (cpu_g1_en_i[c]),
      .fiq_en   (cpu_fiq_en_i[c]),
      .pmask    (pmask_i[c*8 +: 8]),
      .run_prio (run_prio_i[c*9 +: 9]),
      .res      (nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_q <= RES_IDLE;
      else        cur_q <= nxt;
    end

    assign best_id_o[c*ID_W +: ID_W] = cur_q.id;
    assign irq_o[c] = cur_q.irq;
    assign fiq_o[c] = cur_q.fiq;
  end
endmodule

// File: rtl/intsel_chk.sv
module intsel_chk
  import intsel_pkg::*;
#(
  parameter int N_CPU  = 2,
  parameter int N_ID   = 64,
  parameter int N_PRIV = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [N_CPU*N_ID-1:0] ena_i,
  input logic [N_CPU*N_ID-1:0] pend_i,
  input logic [N_CPU*N_ID-1:0] tgt_i,
  input logic [N_ID*8-1:0]     prio_i,
  input logic [1:0]            dist_grp_en_i,
  input logic [N_CPU-1:0]      cpu_if_en_i,
  input logic [N_CPU*8-1:0]    pmask_i,
  input logic [N_CPU*9-1:0]    run_prio_i,
  input logic [N_CPU*10-1:0]   best_id_o,
  input logic [N_CPU-1:0]      irq_o,
  input logic [N_CPU-1:0]      fiq_o
);
  // inputs as seen at the previous edge
  logic [N_CPU*N_ID-1:0] q_ena, q_pend, q_tgt;
  logic [N_ID*8-1:0]     q_prio;
  logic [N_CPU*8-1:0]    q_pmask;
  logic [N_CPU*9-1:0]    q_run;

  always_ff @(posedge clk) begin
    q_ena   <= ena_i;
    q_pend  <= pend_i;
    q_tgt   <= tgt_i;
    q_prio  <= prio_i;
    q_pmask <= pmask_i;
    q_run   <= run_prio_i;
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_c
    logic [ID_W-1:0] rid;
    logic [7:0]      sel_prio;
    logic            sel_ok;

    assign rid = best_id_o[c*ID_W +: ID_W];

    always_comb begin
      sel_prio = 8'h00;
      sel_ok   = 1'b0;
      if (rid < ID_W'(N_ID)) begin
        sel_prio = q_prio[int'(rid)*8 +: 8];
        sel_ok   = q_ena[c*N_ID + int'(rid)] & q_pend[c*N_ID + int'(rid)] &
                   ((int'(rid) < N_PRIV) | q_tgt[c*N_ID + int'(rid)]);
      end
    end

    assert_one_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_o[c] && fiq_o[c]));

    assert_cpu_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_if_en_i[c] || dist_grp_en_i == 2'b00)
      |=> (rid == IDLE_ID && !irq_o[c] && !fiq_o[c]));

    assert_candidate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rid != IDLE_ID) |-> sel_ok);

    assert_below_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rid != IDLE_ID) |-> (sel_prio < q_pmask[c*8 +: 8]));

    assert_preempts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c] || fiq_o[c]) |-> ({1'b0, sel_prio} < q_run[c*9 +: 9]));

    assert_req_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[c] || fiq_o[c]) |-> (rid != IDLE_ID));
  end
endmodule

bind intsel_top intsel_chk #(.N_CPU(N_CPU), .N_ID(N_ID), .N_PRIV(N_PRIV)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ena_i         (ena_i),
  .pend_i        (pend_i),
  .tgt_i         (tgt_i),
  .prio_i        (prio_i),
  .dist_grp_en_i (dist_grp_en_i),
  .cpu_if_en_i   (cpu_if_en_i),
  .pmask_i       (pmask_i),
  .run_prio_i    (run_prio_i),
  .best_id_o     (best_id_o),
  .irq_o         (irq_o),
  .fiq_o         (fiq_o)
);

// File: tb/intsel_top_tb.sv
`timescale 1ns/1ps
module intsel_top_tb;
  localparam int N_CPU  = 2;
  localparam int N_ID   = 64;
  localparam int N_PRIV = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_CPU*N_ID-1:0] ena, pend, tgt;
  logic [N_ID-1:0]       grp;
  logic [N_ID*8-1:0]     prio;
  logic [1:0]            dgrp;
  logic [N_CPU-1:0]      cif, cg0, cg1, cfiq;
  logic [N_CPU*8-1:0]    pmask;
  logic [N_CPU*9-1:0]    rprio;
  logic [N_CPU*10-1:0]   best_id;
  logic [N_CPU-1:0]      irq, fiq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  intsel_top #(.N_CPU(N_CPU), .N_ID(N_ID), .N_PRIV(N_PRIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .ena_i(ena), .pend_i(pend), .tgt_i(tgt),
    .grp_i(grp), .prio_i(prio), .dist_grp_en_i(dgrp), .cpu_if_en_i(cif),
    .cpu_g0_en_i(cg0), .cpu_g1_en_i(cg1), .cpu_fiq_en_i(cfiq),
    .pmask_i(pmask), .run_prio_i(rprio), .best_id_o(best_id),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic check(input int c, input string tag, input int exp_id,
                       input bit exp_irq, input bit exp_fiq);
    int got_id;
    got_id = int'(best_id[c*10 +: 10]);
    n_tests++;
    if (got_id != exp_id || irq[c] != exp_irq || fiq[c] != exp_fiq) begin
      n_fail++;
      $display("FAIL %s cpu%0d: got id=%0d irq=%0b fiq=%0b, expected id=%0d irq=%0b fiq=%0b",
               tag, c, got_id, irq[c], fiq[c], exp_id, exp_irq, exp_fiq);
    end
  endtask

  // expected behaviour derived from the requirements
  task automatic model(input int c, output int e_id, output bit e_irq, output bit e_fiq);
    int bp, bi, g;
    bit gon;
    e_id = 1023; e_irq = 0; e_fiq = 0;
    if (dgrp == 2'b00 || !cif[c] || !(cg0[c] || cg1[c])) return;
    bp = 256; bi = 1023;
    for (int k = 0; k < N_ID; k++) begin
      if (ena[c*N_ID+k] && pend[c*N_ID+k] && (k < N_PRIV || tgt[c*N_ID+k]) &&
          int'(prio[k*8 +: 8]) < bp) begin
        bp = int'(prio[k*8 +: 8]);
        bi = k;
      end
    end
    if (bp < int'(pmask[c*8 +: 8])) begin
      e_id = bi;
      g = int'(grp[bi]);
      gon = (g == 1) ? (dgrp[1] && cg1[c]) : (dgrp[0] && cg0[c]);
      if (bp < int'(rprio[c*9 +: 9]) && gon) begin
        if (g == 0 && cfiq[c]) e_fiq = 1;
        else e_irq = 1;
      end
    end
  endtask

  task automatic clear_all();
    ena = '0; pend = '0; tgt = '0; grp = '0; prio = '0;
    dgrp = 2'b11; cif = '1; cg0 = '1; cg1 = '1; cfiq = '0;
    pmask = {N_CPU{8'hFF}};
    rprio = {N_CPU{9'h100}};
  endtask

  task automatic put(input int c, input int k, input int p, input bit g);
    ena[c*N_ID+k] = 1'b1; pend[c*N_ID+k] = 1'b1; tgt[c*N_ID+k] = 1'b1;
    prio[k*8 +: 8] = 8'(p); grp[k] = g;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int e_id;
    bit e_irq, e_fiq;
    int seed_dummy;
    seed_dummy = $urandom(32'd4242);

    // R1: reset holds idle outputs even with a firing pattern on the inputs
    clear_all();
    put(0, 40, 8'h10, 1'b1);
    put(1, 3, 8'h10, 1'b0);
    repeat (3) @(negedge clk);
    check(0, "R1 reset", 1023, 0, 0);
    check(1, "R1 reset", 1023, 0, 0);
    rst_n = 1'b1;
    settle();

    // R4: nothing pending
    clear_all();
    settle();
    check(0, "R4 empty", 1023, 0, 0);
    check(1, "R4 empty", 1023, 0, 0);

    // R3: tie goes to lowest ID, strictly lower priority wins
    clear_all();
    put(0, 45, 8'h20, 1'b1);
    put(0, 40, 8'h20, 1'b1);
    put(0, 50, 8'h30, 1'b1);
    settle();
    check(0, "R3 tie", 40, 1, 0);
    prio[45*8 +: 8] = 8'h1F;
    settle();
    check(0, "R3 lower", 45, 1, 0);

    // R2: private ID without target bit, shared ID without target bit
    clear_all();
    put(1, 5, 8'h50, 1'b1);
    tgt[1*N_ID+5] = 1'b0;
    put(1, 40, 8'h10, 1'b1);
    tgt[1*N_ID+40] = 1'b0;
    settle();
    check(1, "R2 target", 5, 1, 0);
    check(0, "R2 other cpu", 1023, 0, 0);

    // R5: mask boundary
    clear_all();
    put(0, 33, 8'h40, 1'b1);
    pmask[0 +: 8] = 8'h40;
    settle();
    check(0, "R5 mask equal", 1023, 0, 0);
    pmask[0 +: 8] = 8'h41;
    settle();
    check(0, "R5 mask above", 33, 1, 0);

    // R6: running priority boundary and group enable
    rprio[0 +: 9] = 9'h040;
    settle();
    check(0, "R6 run equal", 33, 0, 0);
    rprio[0 +: 9] = 9'h041;
    settle();
    check(0, "R6 run above", 33, 1, 0);
    cg1[0] = 1'b0;
    settle();
    check(0, "R6 group off", 33, 0, 0);

    // R7: line selection
    clear_all();
    put(0, 12, 8'h08, 1'b0);
    cfiq[0] = 1'b1;
    settle();
    check(0, "R7 g0 fast", 12, 0, 1);
    cfiq[0] = 1'b0;
    settle();
    check(0, "R7 g0 normal", 12, 1, 0);
    grp[12] = 1'b1;
    cfiq[0] = 1'b1;
    settle();
    check(0, "R7 g1", 12, 1, 0);

    // R8: per-CPU gating leaves the other CPU alone
    clear_all();
    put(0, 34, 8'h10, 1'b1);
    put(1, 34, 8'h10, 1'b1);
    cif[0] = 1'b0;
    settle();
    check(0, "R8 if off", 1023, 0, 0);
    check(1, "R8 neighbour", 34, 1, 0);
    cif[0] = 1'b1;
    cg0[1] = 1'b0; cg1[1] = 1'b0;
    settle();
    check(1, "R8 no group", 1023, 0, 0);
    check(0, "R8 neighbour", 34, 1, 0);
    dgrp = 2'b00;
    settle();
    check(0, "R8 dist off", 1023, 0, 0);

    // R9: one-edge latency
    clear_all();
    settle();
    put(1, 7, 8'h22, 1'b1);
    #1;
    check(1, "R9 before edge", 1023, 0, 0);
    settle();
    check(1, "R9 after edge", 7, 1, 0);

    // random patterns checked against the model (R2 R3 R5 R6 R7 R8)
    for (int it = 0; it < 400; it++) begin
      for (int b = 0; b < N_CPU*N_ID; b++) begin
        ena[b]  = ($urandom % 3) != 0;
        pend[b] = ($urandom % 4) == 0;
        tgt[b]  = ($urandom % 2) == 0;
      end
      for (int k = 0; k < N_ID; k++) begin
        prio[k*8 +: 8] = 8'(($urandom % 8) << 5);
        grp[k] = ($urandom % 2) == 0;
      end
      dgrp = (($urandom % 4) == 0) ? 2'($urandom) : 2'b11;
      for (int c = 0; c < N_CPU; c++) begin
        cif[c]  = ($urandom % 10) != 0;
        cg0[c]  = ($urandom % 5) != 0;
        cg1[c]  = ($urandom % 5) != 0;
        cfiq[c] = ($urandom % 2) == 0;
        pmask[c*8 +: 8] = (($urandom % 3) == 0) ? 8'hFF : 8'(($urandom % 9) << 5);
        rprio[c*9 +: 9] = (($urandom % 4) == 0) ? 9'h100 : 9'(($urandom % 8) << 5);
      end
      settle();
      for (int c = 0; c < N_CPU; c++) begin
        model(c, e_id, e_irq, e_fiq);
        check(c, "R3 R5 R6 random", e_id, e_irq, e_fiq);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule